// File: doc/BRIEF.md
# Two-Wire LED Pattern Target

This block is a write-only target on a two-wire serial bus (I2C). It watches the bus clock and data lines with its own system clock, finds START and STOP conditions, compares the 7-bit address of each transfer against its own, acknowledges what it accepts, and assembles incoming bytes. Accepted bytes feed a two-step command scheme that drives a bank of LED outputs.

The arm command byte (0x0A) tells the block that the following data byte is an LED pattern to be stored. The commit command byte (0x0B) copies the stored pattern onto the LED outputs, where it stays until the next commit. The three steps may share one transfer or be spread over several, because the armed state survives STOP and repeated START. Every decision is taken on the complete byte during the acknowledge clock, so the last bit to arrive (bit 0) always counts.

Top module: `i2c_led_cmd_target`

## Requirements
- R1: Only a transfer whose address byte carries the configured 7-bit address (default 2) in bits 7..1 and a 0 in bit 0 is acknowledged. Its data bytes are acted on. The data bytes of a transfer to any other address are neither acknowledged nor acted on.
- R2: An address byte that carries the matching address with bit 0 set (read) is not acknowledged, and any later bytes in that transfer are ignored.
- R3: While not armed, a data byte equal to 0x0A arms the block. While armed, the next data byte is stored as the pattern.
- R4: Pattern bit i drives LED output i (bit 0 to LED 0). Bit 0, the last bit received, is kept.
- R5: A data byte equal to 0x0B received while not armed copies the stored pattern to the LED outputs. The outputs change at no other time.
- R6: The armed state and the stored pattern persist across STOP. Arm, pattern and commit each work when sent in separate transfers.
- R7: The target pulls SDA low during the acknowledge clock of an accepted address and of each data byte of an accepted transfer. It leaves SDA released at all other times.
- R8: While not armed, a data byte other than 0x0A and 0x0B is acknowledged and ignored. Storing a pattern clears the armed state, so the byte after it is decoded as a command again.
- R9: Reset sets the LED outputs, the stored pattern and the armed state to zero.
- R10: A repeated START restarts address matching at once, and the armed state carries through it.
- R11: While armed, a byte equal to 0x0A or 0x0B is stored as the pattern and is not decoded as a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| led_o | output | LED_COUNT | LED outputs, bit i driven by pattern bit i |

## Verification
The bench sends patterns with bit 0 set, such as 0xA5 and 0x81. A design that decodes before the acknowledge clock would show these with LED 0 cleared. It sends 0x0A and 0x0B as pattern bytes while armed; a decoder that checks for commands first would re-arm or commit early. It splits arm, pattern and commit across separate transfers and across a repeated START, and sends a read-direction address, a foreign address and a mid-run reset. A block that lost the armed state, acked foreign traffic or kept state through reset would commit the wrong pattern. The LED outputs and the SDA pull are compared against a behavioural model on every clock.

// File: rtl/i2c_led_pkg.sv
package i2c_led_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_ADDR_ACK,
      PH_DATA,
      PH_DATA_ACK,
      PH_SKIP
   } phase_t;
endpackage

// File: rtl/i2c_led_sync.sv
module i2c_led_sync #(
   parameter int W = 2,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RESET_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_led_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RESET_VAL;
      else        chain[0] <= d_i;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RESET_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/i2c_led_bus_events.sv
module i2c_led_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det,
   output logic sda_bit
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
   assign sda_bit   =  sda_s;
endmodule

// File: rtl/i2c_led_byte_rx.sv
module i2c_led_byte_rx
   import i2c_led_pkg::*;
#(
   parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'h02
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_bit,
   output logic              byte_valid,
   output logic [BYTE_W-1:0] byte_data,
   output logic              sda_pull
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   phase_t             phase;
   logic [CNT_W-1:0]   bit_cnt;
   logic [BYTE_W-1:0]  shreg;
   logic [BYTE_W-1:0]  hold;
   logic               addr_ok;

   assign addr_ok = (shreg[BYTE_W-1:1] == TARGET_ADDR) && !shreg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         bit_cnt    <= '0;
         shreg      <= '0;
         hold       <= '0;
         sda_pull   <= 1'b0;
         byte_valid <= 1'b0;
      end else begin
         byte_valid <= 1'b0;
         if (start_det) begin
            phase    <= PH_ADDR;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
         end else if (stop_det) begin
            phase    <= PH_IDLE;
            sda_pull <= 1'b0;
         end else begin
            unique case (phase)
               PH_ADDR, PH_DATA: begin
                  if (scl_rise && bit_cnt < FULL) begin
                     shreg   <= {shreg[BYTE_W-2:0], sda_bit};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == FULL) begin
                     if (phase == PH_ADDR) begin
                        if (addr_ok) begin
                           sda_pull <= 1'b1;
                           phase    <= PH_ADDR_ACK;
                        end else begin
                           phase    <= PH_SKIP;
                        end
                     end else begin
                        hold     <= shreg;
                        sda_pull <= 1'b1;
                        phase    <= PH_DATA_ACK;
                     end
                  end
               end
               PH_ADDR_ACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     bit_cnt  <= '0;
                     phase    <= PH_DATA;
                  end
               end
               PH_DATA_ACK: begin
                  if (scl_rise) byte_valid <= 1'b1;
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     bit_cnt  <= '0;
                     phase    <= PH_DATA;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign byte_data = hold;

   AST_PULL_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      sda_pull |-> (phase == PH_ADDR_ACK || phase == PH_DATA_ACK)); // R7
   AST_BYTE_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> $past(phase) == PH_DATA_ACK); // R1
   AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SKIP && !start_det) |=> !byte_valid && !sda_pull); // R2
   AST_RESTART_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> phase == PH_ADDR); // R10
endmodule

// File: rtl/i2c_led_cmd_decode.sv
module i2c_led_cmd_decode
   import i2c_led_pkg::*;
#(
   parameter int LED_COUNT = 8,
   parameter logic [BYTE_W-1:0] CMD_ARM = 8'h0A,
   parameter logic [BYTE_W-1:0] CMD_COMMIT = 8'h0B
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 byte_valid,
   input  logic [BYTE_W-1:0]    byte_data,
   output logic [LED_COUNT-1:0] led
);
   logic              armed;
   logic [BYTE_W-1:0] pattern;
   logic              commit;

   generate
      if (LED_COUNT < 1 || LED_COUNT > BYTE_W) begin : g_bad_leds
         $error("i2c_led_cmd_decode: LED_COUNT out of range");
      end
      if (CMD_ARM == CMD_COMMIT) begin : g_bad_cmds
         $error("i2c_led_cmd_decode: command codes must differ");
      end
   endgenerate

   assign commit = byte_valid && !armed && (byte_data == CMD_COMMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         pattern <= '0;
         led     <= '0;
      end else if (byte_valid) begin
         if (armed) begin
            pattern <= byte_data;
            armed   <= 1'b0;
         end else if (byte_data == CMD_ARM) begin
            armed   <= 1'b1;
         end else if (commit) begin
            led     <= pattern[LED_COUNT-1:0];
         end
      end
   end

   AST_PATTERN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(byte_valid && armed) |=> $stable(pattern)); // R3
   AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && armed) |=> !armed); // R8
   AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(led)); // R5
endmodule

// File: rtl/i2c_led_cmd_target.sv
module i2c_led_cmd_target
   import i2c_led_pkg::*;
#(
   parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'h02,
   parameter int SYNC_STAGES = 2,
   parameter int LED_COUNT = 8,
   parameter logic [BYTE_W-1:0] CMD_ARM = 8'h0A,
   parameter logic [BYTE_W-1:0] CMD_COMMIT = 8'h0B
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_i,
   input  logic                 sda_i,
   output logic                 sda_pull_o,
   output logic [LED_COUNT-1:0] led_o
);
   logic [1:0]        bus_s;
   logic              scl_rise, scl_fall, start_det, stop_det, sda_bit;
   logic              byte_valid;
   logic [BYTE_W-1:0] byte_data;

   i2c_led_sync #(.W(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b11)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({scl_i, sda_i}),
      .q_o   (bus_s)
   );

   i2c_led_bus_events events_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (bus_s[1]),
      .sda_s     (bus_s[0]),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_bit   (sda_bit)
   );

   i2c_led_byte_rx #(.TARGET_ADDR(TARGET_ADDR)) rx_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .sda_bit    (sda_bit),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .sda_pull   (sda_pull_o)
   );

   i2c_led_cmd_decode #(
      .LED_COUNT  (LED_COUNT),
      .CMD_ARM    (CMD_ARM),
      .CMD_COMMIT (CMD_COMMIT)
   ) dec_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .led        (led_o)
   );
endmodule

// File: tb/i2c_led_cmd_target_tb.sv
module i2c_led_cmd_target_tb_top;
   localparam int Q = 25;
   localparam logic [6:0] MY_ADDR = 7'h02;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_pull_o;
   logic [7:0] led_o;
   logic sda_line;

   int checks = 0;
   int errors = 0;
   bit settle = 1'b0;
   bit ack_win = 1'b0;
   bit m_armed = 1'b0;
   bit m_addressed = 1'b0;
   logic [7:0] m_pattern = 8'h00;
   logic [7:0] m_led = 8'h00;

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~sda_pull_o;

   i2c_led_cmd_target dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_line),
      .sda_pull_o (sda_pull_o),
      .led_o      (led_o)
   );

   // per-clock comparison against the behavioural model
   always @(negedge clk) begin
      if (rst_n && !settle) begin
         checks++;
         if (led_o !== m_led) begin
            errors++;
            $display("FAIL R5 led_o per-clock: actual %h expected %h", led_o, m_led);
         end
      end
      if (rst_n && !ack_win) begin
         checks++;
         if (sda_pull_o !== 1'b0) begin
            errors++;
            $display("FAIL R7 sda pull outside ack: actual %b expected 0", sda_pull_o);
         end
      end
   end

   task automatic wq(int n);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; wq(1);
      sda_m = 1'b0; wq(1);
      scl_m = 1'b0; wq(1);
   endtask

   task automatic bus_restart();
      sda_m = 1'b1; wq(1);
      scl_m = 1'b1; wq(1);
      sda_m = 1'b0; wq(1);
      scl_m = 1'b0; wq(1);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(1);
      scl_m = 1'b1; wq(1);
      sda_m = 1'b1; wq(1);
   endtask

   task automatic model_byte(logic [7:0] b);
      if (m_armed) begin
         m_pattern = b;
         m_armed = 1'b0;
      end else if (b == 8'h0A) begin
         m_armed = 1'b1;
      end else if (b == 8'h0B) begin
         m_led = m_pattern;
      end
   endtask

   // sends 8 bits plus the ack clock; is_data selects model update
   task automatic send_byte(logic [7:0] b, bit exp_ack, bit is_data, string req);
      bit got_ack;
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(1);
         scl_m = 1'b1; wq(2);
         scl_m = 1'b0;
         if (i == 0) ack_win = 1'b1;
         wq(1);
      end
      sda_m = 1'b1; wq(1);
      scl_m = 1'b1;
      if (is_data) settle = 1'b1;
      wq(1);
      got_ack = !sda_line;
      checks++;
      if (got_ack !== exp_ack) begin
         errors++;
         $display("FAIL %s ack for byte %h: actual %b expected %b", req, b, got_ack, exp_ack);
      end
      wq(1);
      scl_m = 1'b0; wq(1);
      if (is_data && m_addressed) model_byte(b);
      settle = 1'b0;
      ack_win = 1'b0;
   endtask

   task automatic send_addr(logic [6:0] a, bit rd, string req);
      bit match;
      match = (a == MY_ADDR) && !rd;
      send_byte({a, rd}, match, 1'b0, req);
      m_addressed = match;
   endtask

   task automatic txn(logic [6:0] a, logic [7:0] bytes[$], string req);
      bus_start();
      send_addr(a, 1'b0, req);
      foreach (bytes[k]) send_byte(bytes[k], m_addressed, 1'b1, req);
      bus_stop();
      wq(2);
   endtask

   task automatic check_led(logic [7:0] exp, string req);
      checks++;
      if (led_o !== exp) begin
         errors++;
         $display("FAIL %s led_o: actual %h expected %h", req, led_o, exp);
      end
   endtask

   task automatic finish_sim();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
   end

   initial begin
      repeat (10) @(negedge clk);
      check_led(8'h00, "R9");
      rst_n = 1'b1;
      wq(2);

      // R3 R4 R5: arm, pattern with bit0 set, commit
      txn(MY_ADDR, '{8'h0A, 8'hA5, 8'h0B}, "R3");
      check_led(8'hA5, "R4");

      // R6: separate transfers
      txn(MY_ADDR, '{8'h0A}, "R6");
      txn(MY_ADDR, '{8'h3C}, "R6");
      check_led(8'hA5, "R5");
      txn(MY_ADDR, '{8'h0B}, "R6");
      check_led(8'h3C, "R6");

      // R8: unknown byte ignored, repeat commit holds
      txn(MY_ADDR, '{8'h55, 8'h0B}, "R8");
      check_led(8'h3C, "R8");

      // R8: arm clears after pattern store
      txn(MY_ADDR, '{8'h0A, 8'h81, 8'h77, 8'h0B}, "R8");
      check_led(8'h81, "R8");

      // R11: command codes as pattern bytes
      txn(MY_ADDR, '{8'h0A, 8'h0B, 8'h0B}, "R11");
      check_led(8'h0B, "R11");
      txn(MY_ADDR, '{8'h0A, 8'h0A, 8'h0B}, "R11");
      check_led(8'h0A, "R11");

      // R1: foreign address ignored
      txn(7'h03, '{8'h0A, 8'hFF}, "R1");
      txn(MY_ADDR, '{8'h0B}, "R1");
      check_led(8'h0A, "R1");

      // R2: read direction not accepted
      bus_start();
      send_addr(MY_ADDR, 1'b1, "R2");
      send_byte(8'h0A, 1'b0, 1'b1, "R2");
      send_byte(8'hF0, 1'b0, 1'b1, "R2");
      bus_stop();
      wq(2);
      txn(MY_ADDR, '{8'h0B}, "R2");
      check_led(8'h0A, "R2");

      // R10: repeated start after foreign address
      bus_start();
      send_addr(7'h05, 1'b0, "R10");
      bus_restart();
      send_addr(MY_ADDR, 1'b0, "R10");
      send_byte(8'h0A, 1'b1, 1'b1, "R10");
      send_byte(8'h5A, 1'b1, 1'b1, "R10");
      send_byte(8'h0B, 1'b1, 1'b1, "R10");
      bus_stop();
      wq(2);
      check_led(8'h5A, "R10");

      // R10: armed state carried through repeated start
      bus_start();
      send_addr(MY_ADDR, 1'b0, "R10");
      send_byte(8'h0A, 1'b1, 1'b1, "R10");
      bus_restart();
      send_addr(MY_ADDR, 1'b0, "R10");
      send_byte(8'hC3, 1'b1, 1'b1, "R10");
      send_byte(8'h0B, 1'b1, 1'b1, "R10");
      bus_stop();
      wq(2);
      check_led(8'hC3, "R10");

      // R9: reset mid-run clears leds, pattern, armed
      txn(MY_ADDR, '{8'h0A, 8'hFF, 8'h0A}, "R9");
      rst_n = 1'b0;
      m_armed = 1'b0; m_pattern = 8'h00; m_led = 8'h00;
      repeat (5) @(negedge clk);
      check_led(8'h00, "R9");
      rst_n = 1'b1;
      wq(2);
      txn(MY_ADDR, '{8'h0B}, "R9");
      check_led(8'h00, "R9");
      txn(MY_ADDR, '{8'h66, 8'h0B}, "R9");
      check_led(8'h00, "R9");

      finish_sim();
   end
endmodule